// File: doc/BRIEF.md
# Sliced Sign-Magnitude Multiplier

This block multiplies two integers held in sign-magnitude form. Each operand comes in as a separate sign bit and an unsigned magnitude of even width `W`. The magnitudes are cut into 2-bit digits. Every digit-by-digit product is taken from a small 2x2 table built by bit inspection, so the datapath contains no multiply operator.

The partial products are summed column by column. Column `k` collects every product whose two digit indices add up to `k`, together with the carry from column `k-1`. Its two low bits become result digit `k`, and the bits above them are carried on to column `k+1`. The last column supplies the top four bits of the `2W`-bit magnitude.

The product sign is the XOR of the operand signs, except when the magnitude is zero. A build parameter can swap the table for a per-digit multiply operator. A second build parameter places a register on the outputs.

Top module: `smul_top`

## Requirements
- R1: `p_mag_o` equals the full unsigned product `a_mag_i * b_mag_i`, `2*W` bits wide, for every pair of magnitudes and for `W` of 4, 8 and 16.
- R2: A digit product follows the 2x2 table. Any zero digit gives 0. The nonzero entries are 1x1=1, 1x2=2, 1x3=3, 2x2=4, 2x3=6 and 3x3=9. With both magnitudes below 4, the product equals the table entry.
- R3: Result bits [1:0] equal the low two bits of the product of the two least significant digits.
- R4: Result digit `k` is bits [1:0] of column sum `k`. The bits of that sum above bit 1 carry into column `k+1`, and the last column gives the top 4 bits. For W=4, magnitudes 1010 and 1100 give 01111000, and 1111 times 1111 gives 11100001.
- R5: `p_sign_o` is `a_sign_i XOR b_sign_i` whenever the product magnitude is nonzero.
- R6: When the product magnitude is zero, `p_sign_o` is 0 whatever the input signs, so negative zero never appears.
- R7: With `USE_MUL_OP=1` the digit products come from a multiply operator. The outputs are identical to the table build for every input.
- R8: With `REG_OUT=1`, the outputs show the result one clock edge after the inputs, and reset (`rst_ni` low) clears both outputs to 0. With `REG_OUT=0` the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_sign_i | input | 1 | Sign of operand A (1 = negative) |
| a_mag_i | input | W | Magnitude of operand A |
| b_sign_i | input | 1 | Sign of operand B (1 = negative) |
| b_mag_i | input | W | Magnitude of operand B |
| p_sign_o | output | 1 | Sign of the product |
| p_mag_o | output | 2*W | Magnitude of the product |

## Verification
The hardest situation to reach is a long carry chain: column sums large enough that several bits above the digit travel into the next column. This happens only when many digits are 3 at the same time. The stimulus reaches it with directed all-ones operands at every width, exhaustive coverage at W=4, and random 8- and 16-bit magnitudes. The zero-magnitude sign rule needs a zero operand paired with opposite signs, so the bench forces those combinations directly.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef logic [1:0] digit_t;
  typedef logic [3:0] pp_t;

  // 2x2 product by bit inspection
  function automatic pp_t pp_lookup(digit_t m, digit_t r);
    pp_t p;
    unique case ({m, r})
      4'b01_01: p = 4'd1;
      4'b01_10: p = 4'd2;
      4'b01_11: p = 4'd3;
      4'b10_01: p = 4'd2;
      4'b10_10: p = 4'd4;
      4'b10_11: p = 4'd6;
      4'b11_01: p = 4'd3;
      4'b11_10: p = 4'd6;
      4'b11_11: p = 4'd9;
      default:  p = 4'd0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/smul_pp_cell.sv
module smul_pp_cell
  import smul_pkg::*;
#(
  parameter bit USE_MUL_OP = 1'b0
) (
  input  digit_t m_i,
  input  digit_t r_i,
  output pp_t    pp_o
);
  generate
    if (USE_MUL_OP) begin : g_mul
      assign pp_o = pp_t'(m_i) * pp_t'(r_i);
    end else begin : g_lut
      assign pp_o = pp_lookup(m_i, r_i);
    end
  endgenerate
endmodule

// File: rtl/smul_col_sum.sv
module smul_col_sum #(
  parameter int D  = 2,
  parameter int K  = 0,
  parameter int SW = 8
) (
  input  logic [D*D*4-1:0] pp_i,
  input  logic [SW-1:0]    cin_i,
  output logic [SW-1:0]    sum_o
);
  // adds every partial product whose digit indices sum to K
  always_comb begin
    sum_o = cin_i;
    for (int i = 0; i < D; i++) begin
      for (int j = 0; j < D; j++) begin
        if (i + j == K) sum_o = sum_o + SW'(pp_i[(i*D+j)*4 +: 4]);
      end
    end
  end
endmodule

// File: rtl/smul_sign.sv
module smul_sign (
  input  logic a_sign_i,
  input  logic b_sign_i,
  input  logic mag_nz_i,
  output logic sign_o
);
  assign sign_o = (a_sign_i ^ b_sign_i) & mag_nz_i;
endmodule

// File: rtl/smul_top.sv
module smul_top
  import smul_pkg::*;
#(
  parameter int W          = 4,
  parameter bit USE_MUL_OP = 1'b0,
  parameter bit REG_OUT    = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           a_sign_i,
  input  logic [W-1:0]   a_mag_i,
  input  logic           b_sign_i,
  input  logic [W-1:0]   b_mag_i,
  output logic           p_sign_o,
  output logic [2*W-1:0] p_mag_o
);
  localparam int D  = W / 2;
  localparam int NC = 2 * D - 1;
  localparam int PW = 2 * W;
  localparam int SW = 8 + $clog2(D + 1);

  logic [D*D*4-1:0] pp_flat;
  logic [SW-1:0]    carry [NC+1];
  logic [SW-1:0]    csum  [NC];
  logic [PW-1:0]    mag_c;
  logic             sign_c;

  generate
    for (genvar i = 0; i < D; i++) begin : g_m
      for (genvar j = 0; j < D; j++) begin : g_r
        smul_pp_cell #(.USE_MUL_OP(USE_MUL_OP)) u_cell (
          .m_i (a_mag_i[2*i +: 2]),
          .r_i (b_mag_i[2*j +: 2]),
          .pp_o(pp_flat[(i*D+j)*4 +: 4])
        );
      end
    end

    assign carry[0] = '0;
    for (genvar k = 0; k < NC; k++) begin : g_col
      smul_col_sum #(.D(D), .K(k), .SW(SW)) u_col (
        .pp_i (pp_flat),
        .cin_i(carry[k]),
        .sum_o(csum[k])
      );
      assign carry[k+1] = {2'b00, csum[k][SW-1:2]};
      if (k < NC - 1) begin : g_dig
        assign mag_c[2*k +: 2] = csum[k][1:0];
      end else begin : g_top
        assign mag_c[PW-1:2*k] = csum[k][3:0];
      end
    end
  endgenerate

  smul_sign u_sign (
    .a_sign_i(a_sign_i),
    .b_sign_i(b_sign_i),
    .mag_nz_i(|mag_c),
    .sign_o  (sign_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          p_sign_o <= 1'b0;
          p_mag_o  <= '0;
        end else begin
          p_sign_o <= sign_c;
          p_mag_o  <= mag_c;
        end
      end
    end else begin : g_comb
      assign p_sign_o = sign_c;
      assign p_mag_o  = mag_c;
    end
  endgenerate
endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           a_sign_i,
  input logic [W-1:0]   a_mag_i,
  input logic           b_sign_i,
  input logic [W-1:0]   b_mag_i,
  input logic           p_sign_o,
  input logic [2*W-1:0] p_mag_o
);
  localparam int PW = 2 * W;
  logic [PW-1:0] ref_prod;
  logic [3:0]    ref_low;
  logic          ref_sign;
  logic          armed;

  assign ref_prod = PW'(a_mag_i) * PW'(b_mag_i);
  assign ref_low  = 4'(a_mag_i[1:0]) * 4'(b_mag_i[1:0]);
  assign ref_sign = (a_sign_i != b_sign_i) && (a_mag_i != '0) && (b_mag_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R6
  a_r6_no_neg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_mag_o == '0) |-> !p_sign_o);

  generate
    if (REG_OUT) begin : g_seq
      a_r1_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed |-> p_mag_o == $past(ref_prod));
      a_r3_low_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed |-> p_mag_o[1:0] == $past(ref_low[1:0]));
      a_r5_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed |-> p_sign_o == $past(ref_sign));
      a_r8_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !armed |-> (p_mag_o == '0) && !p_sign_o);
    end else begin : g_cmb
      a_r1_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
        p_mag_o == ref_prod);
      a_r3_low_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        p_mag_o[1:0] == ref_low[1:0]);
      a_r5_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        p_sign_o == ref_sign);
    end
  endgenerate
endmodule

bind smul_top smul_checker #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_sign_i(a_sign_i),
  .a_mag_i (a_mag_i),
  .b_sign_i(b_sign_i),
  .b_mag_i (b_mag_i),
  .p_sign_o(p_sign_o),
  .p_mag_o (p_mag_o)
);

// File: tb/smul_top_test.sv
`timescale 1ns/1ps
module smul_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // W=4 stimulus shared by three builds
  logic       as4, bs4;
  logic [3:0] am4, bm4;
  logic       s_lut, s_mul, s_cmb;
  logic [7:0] m_lut, m_mul, m_cmb;
  // wide builds
  logic        as8, bs8, s8;
  logic [7:0]  am8, bm8;
  logic [15:0] m8;
  logic        as16, bs16, s16;
  logic [15:0] am16, bm16;
  logic [31:0] m16;

  smul_top #(.W(4), .USE_MUL_OP(1'b0), .REG_OUT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .a_sign_i(as4), .a_mag_i(am4),
    .b_sign_i(bs4), .b_mag_i(bm4), .p_sign_o(s_lut), .p_mag_o(m_lut));
  smul_top #(.W(4), .USE_MUL_OP(1'b1), .REG_OUT(1'b1)) uut_mul (
    .clk_i(clk), .rst_ni(rst_n), .a_sign_i(as4), .a_mag_i(am4),
    .b_sign_i(bs4), .b_mag_i(bm4), .p_sign_o(s_mul), .p_mag_o(m_mul));
  smul_top #(.W(4), .USE_MUL_OP(1'b0), .REG_OUT(1'b0)) uut_cmb (
    .clk_i(clk), .rst_ni(rst_n), .a_sign_i(as4), .a_mag_i(am4),
    .b_sign_i(bs4), .b_mag_i(bm4), .p_sign_o(s_cmb), .p_mag_o(m_cmb));
  smul_top #(.W(8), .USE_MUL_OP(1'b0), .REG_OUT(1'b1)) uut8 (
    .clk_i(clk), .rst_ni(rst_n), .a_sign_i(as8), .a_mag_i(am8),
    .b_sign_i(bs8), .b_mag_i(bm8), .p_sign_o(s8), .p_mag_o(m8));
  smul_top #(.W(16), .USE_MUL_OP(1'b1), .REG_OUT(1'b1)) uut16 (
    .clk_i(clk), .rst_ni(rst_n), .a_sign_i(as16), .a_mag_i(am16),
    .b_sign_i(bs16), .b_mag_i(bm16), .p_sign_o(s16), .p_mag_o(m16));

  function automatic logic exp_sign(logic sa, logic sb, logic [31:0] p);
    return (sa ^ sb) && (p != 0);
  endfunction

  function automatic logic [3:0] table_pp(logic [1:0] m, logic [1:0] r);
    logic [3:0] p = 4'd0;
    for (int k = 0; k < 2; k++) if (r[k]) p = p + ({2'b00, m} << k);
    return p;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // drive W=4 at a negedge, check comb now and registered at the next negedge
  task automatic run4(logic sa, logic [3:0] a, logic sb, logic [3:0] b);
    logic [7:0] p;
    p = 8'(a) * 8'(b);
    as4 = sa; am4 = a; bs4 = sb; bm4 = b;
    #1;
    check("R8 comb same cycle", {24'd0, m_cmb}, {24'd0, p});
    check("R5 R6 comb sign", {31'd0, s_cmb}, {31'd0, exp_sign(sa, sb, 32'(p))});
    @(negedge clk);
    check("R1 W4 magnitude", {24'd0, m_lut}, {24'd0, p});
    check("R5 R6 W4 sign", {31'd0, s_lut}, {31'd0, exp_sign(sa, sb, 32'(p))});
    check("R7 mul build equal", {23'd0, s_mul, m_mul}, {23'd0, s_lut, m_lut});
    check("R3 low digit", {30'd0, m_lut[1:0]}, {30'd0, table_pp(a[1:0], b[1:0])} & 32'h3);
    if (a < 4 && b < 4)
      check("R2 digit table", {24'd0, m_lut}, {28'd0, table_pp(a[1:0], b[1:0])});
  endtask

  task automatic run_wide(logic [15:0] a8v, logic [15:0] b8v, logic [15:0] a16v,
                          logic [15:0] b16v, logic s1, logic s2, logic s3, logic s4);
    logic [15:0] p8;
    logic [31:0] p16;
    p8  = 16'(a8v[7:0]) * 16'(b8v[7:0]);
    p16 = 32'(a16v) * 32'(b16v);
    as8 = s1; bs8 = s2; am8 = a8v[7:0]; bm8 = b8v[7:0];
    as16 = s3; bs16 = s4; am16 = a16v; bm16 = b16v;
    @(negedge clk);
    check("R1 W8 magnitude", {16'd0, m8}, {16'd0, p8});
    check("R5 W8 sign", {31'd0, s8}, {31'd0, exp_sign(s1, s2, 32'(p8))});
    check("R1 R7 W16 magnitude", m16, p16);
    check("R5 W16 sign", {31'd0, s16}, {31'd0, exp_sign(s3, s4, p16)});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20160611);
    as4 = 1'b1; bs4 = 1'b0; am4 = 4'hF; bm4 = 4'hF;
    as8 = 1'b0; bs8 = 1'b0; am8 = '0; bm8 = '0;
    as16 = 1'b0; bs16 = 1'b0; am16 = '0; bm16 = '0;
    repeat (3) @(negedge clk);
    check("R8 reset mag", {24'd0, m_lut}, 32'd0);
    check("R8 reset sign", {31'd0, s_lut}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 worked case and full carry case
    run4(1'b0, 4'b1010, 1'b0, 4'b1100);
    check("R4 worked case", {24'd0, m_lut}, 32'h78);
    run4(1'b1, 4'b1111, 1'b0, 4'b1111);
    check("R4 all ones", {24'd0, m_lut}, 32'hE1);
    // R6 zero operand with differing signs
    run4(1'b1, 4'd0, 1'b0, 4'd9);
    check("R6 zero sign", {31'd0, s_lut}, 32'd0);
    run4(1'b0, 4'd7, 1'b1, 4'd0);
    check("R6 zero sign b", {31'd0, s_lut}, 32'd0);

    // R8 latency: registered output holds the previous result until the edge
    as4 = 1'b0; am4 = 4'd3; bs4 = 1'b0; bm4 = 4'd5;
    #1;
    check("R8 hold before edge", {24'd0, m_lut}, 32'd0);
    @(negedge clk);
    check("R8 after edge", {24'd0, m_lut}, 32'd15);

    // exhaustive W=4
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run4(1'($urandom), 4'(a), 1'($urandom), 4'(b));

    // wide corner cases then random
    run_wide(16'hFF, 16'hFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1);
    run_wide(16'h0, 16'hAB, 16'h0, 16'h1234, 1'b1, 1'b0, 1'b1, 1'b0);
    run_wide(16'h80, 16'h80, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int n = 0; n < 300; n++)
      run_wide(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    summary();
  end
endmodule